// File: doc/BRIEF.md
# Masked Vector Gather Load Sequencer

This block loads 32-bit elements from scattered memory locations into a vector destination register. A mask selects which elements are loaded. The address of each element is a common 64-bit base plus a signed per-element index multiplied by a small power-of-two scale. The indices can be 32 or 64 bits wide, and a narrow or wide vector mode sets how many elements take part. On a start pulse the block captures its operands and zeroes the register lanes that have no element. It then steps through the lanes from the lowest upward and issues one read for each enabled lane. Each returned word is merged into its lane, and that lane's mask element is cleared.

Progress is recorded in the mask itself. When a read comes back with a fault, the block stops and reports the faulting lane. The partly updated destination and mask are presented on the outputs. The caller can feed both back as inputs and start again, and the second run fetches only the lanes that are still pending. A successful run ends with the whole mask at zero.

Top module: `gather_seq`

## Requirements
- R1: Each read address is `base_addr + (sign-extended index << cfg_scale)`, computed modulo 2^64. The scale code 0/1/2/3 selects a factor of 1/2/4/8.
- R2: A lane is enabled only when bit 31 of its 32-bit mask element is 1. A disabled lane is never read, and its destination element keeps the value it was given at start.
- R3: The element count is 8 with 32-bit indices in wide mode (`cfg_wide`=1), 4 with 32-bit indices in narrow mode, 4 with 64-bit indices (`cfg_idx64`=1) in wide mode, and 2 with 64-bit indices in narrow mode. Lane e takes its 32-bit index from `index_vec[32e+31:32e]`, or its 64-bit index from `index_vec[64e+63:64e]`. Lane e lives at bits [32e+31:32e] of the destination and mask vectors.
- R4: From the cycle after start, every lane at or above the element count reads zero in both `dst_out` and `mask_out`. This holds even when the very first read faults.
- R5: Reads are issued in ascending lane order, with only one outstanding at a time. A request holds its valid signal and a stable address until it is accepted. No new request appears before the response to the previous one.
- R6: A good response writes its data into the lane that was read and clears that lane's mask element.
- R7: On successful completion, `done` pulses high for exactly one cycle. In that cycle `mask_out` is all zero and `dst_out` holds the final result.
- R8: A response with `rd_rsp_fault`=1 ends the run. `fault` pulses for one cycle and `fault_lane` names the faulting lane. Lanes gathered before the fault keep their data with their mask cleared, and the faulting and later lanes keep their mask. Restarting with the outputs fed back fetches only the lanes still pending.
- R9: If no lane in range is enabled at start, `done` pulses without any read being issued.
- R10: A start pulse that arrives while a run is in progress is ignored and has no effect on that run's reads or results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a gather; operands are captured in this cycle |
| cfg_wide | input | 1 | 1 = wide vector mode, 0 = narrow |
| cfg_idx64 | input | 1 | 1 = 64-bit indices, 0 = 32-bit indices |
| cfg_scale | input | 2 | Index scale code (factor 1, 2, 4, 8) |
| base_addr | input | 64 | Common base address |
| index_vec | input | 256 | Packed per-lane indices |
| dst_in | input | 256 | Destination value at start |
| mask_in | input | 256 | Mask value at start |
| dst_out | output | 256 | Current destination register |
| mask_out | output | 256 | Current mask register |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 64 | Read address |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_ready | output | 1 | Block waiting for a response |
| rd_rsp_data | input | 32 | Read data |
| rd_rsp_fault | input | 1 | Response carries a fault |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle fault pulse |
| fault_lane | output | 3 | Lane whose read faulted |

## Verification
The bench builds the block with its default of eight lanes. That is the one size at which all four mode combinations (8, 4, 4 and 2 elements) and the zeroing of every unused lane group can be reached. The responder varies the request-ready and response delays from cycle to cycle, so held requests and back-to-back lanes both occur. The bench injects faults on the first read and on a later read, and it restarts a faulted run. Negative indices and a base near the top of the address space exercise sign extension and address wrap.

// File: rtl/gather_pkg.sv
// Shared definitions for the gather sequencer.
// Assumes 32-bit elements and 64-bit addresses throughout.
package gather_pkg;
    localparam int ELEM_W = 32;
    localparam int ADDR_W = 64;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_REQ,
        ST_WAIT
    } gstate_t;
endpackage

// File: rtl/gather_addr_gen.sv
// Captures base, indices, index width and scale at start. It forms the read
// address of the lane selected by the sequencer. Assumes LANES is a power of
// two and that the lane input is below the element count whenever the
// address is used.
module gather_addr_gen #(
    parameter int LANES = 8,
    parameter int CNT_W = $clog2(LANES + 1),
    localparam int VW    = LANES * gather_pkg::ELEM_W,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [gather_pkg::ADDR_W-1:0] base_in,
    input  logic [VW-1:0]                 idx_in,
    input  logic                          idx64_in,
    input  logic [1:0]                    scale_in,
    input  logic [CNT_W-1:0]              lane,
    output logic [gather_pkg::ADDR_W-1:0] addr
);
    logic [gather_pkg::ADDR_W-1:0] base_q;
    logic [VW-1:0]                 idx_q;
    logic                          idx64_q;
    logic [1:0]                    scale_q;
    logic [SEL_W-1:0]              sel;
    logic [SEL_W-2:0]              sel64;
    logic [31:0]                   idx32;
    logic [63:0]                   idx_ext;

    // Hold the operands for the whole run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            idx_q   <= '0;
            idx64_q <= 1'b0;
            scale_q <= '0;
        end else if (load) begin
            base_q  <= base_in;
            idx_q   <= idx_in;
            idx64_q <= idx64_in;
            scale_q <= scale_in;
        end
    end

    // Pick the lane index, sign-extend it, scale it and add the base.
    always_comb begin
        sel     = lane[SEL_W-1:0];
        sel64   = sel[SEL_W-2:0];
        idx32   = idx_q[32*sel +: 32];
        idx_ext = idx64_q ? idx_q[64*sel64 +: 64] : {{32{idx32[31]}}, idx32};
        addr    = base_q + (idx_ext << scale_q);
    end
endmodule

// File: rtl/gather_lane_file.sv
// Destination and mask registers, one 32-bit lane each. At load, lanes below
// the element count take the inputs and the rest are zeroed. A good response
// writes one lane and clears its mask. Completion clears the whole mask.
module gather_lane_file #(
    parameter int LANES = 8,
    parameter int CNT_W = $clog2(LANES + 1),
    localparam int EW = gather_pkg::ELEM_W,
    localparam int VW = LANES * EW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] n_lanes,
    input  logic [VW-1:0]    dst_in,
    input  logic [VW-1:0]    mask_in,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] cur_lane,
    input  logic [EW-1:0]    wr_data,
    input  logic             clr_mask,
    output logic [VW-1:0]    dst_q,
    output logic [VW-1:0]    mask_q,
    output logic             cur_en
);
    logic [EW-1:0] dst_r  [LANES];
    logic [EW-1:0] mask_r [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Per-lane update: load and zero, merge a response, or clear at the end.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dst_r[g]  <= '0;
                mask_r[g] <= '0;
            end else if (load) begin
                dst_r[g]  <= (CNT_W'(g) < n_lanes) ? dst_in[EW*g +: EW]  : '0;
                mask_r[g] <= (CNT_W'(g) < n_lanes) ? mask_in[EW*g +: EW] : '0;
            end else if (clr_mask) begin
                mask_r[g] <= '0;
            end else if (wr_en && cur_lane == CNT_W'(g)) begin
                dst_r[g]  <= wr_data;
                mask_r[g] <= '0;
            end
        end
        assign dst_q[EW*g +: EW]  = dst_r[g];
        assign mask_q[EW*g +: EW] = mask_r[g];
    end

    // Enable bit of the lane under the cursor; zero past the last lane.
    always_comb begin
        cur_en = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (cur_lane == CNT_W'(i)) cur_en = mask_r[i][EW-1];
        end
    end
endmodule

// File: rtl/gather_fsm.sv
// Sequencer: walks the lanes from the lowest upward, issues one read per
// enabled lane, and waits for each response before moving on. It produces the
// one-cycle done and fault pulses. Assumes LANES is a multiple of 4.
module gather_fsm #(
    parameter int LANES = 8,
    parameter int CNT_W = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cfg_wide,
    input  logic             cfg_idx64,
    input  logic             cur_en,
    input  logic             req_ready,
    input  logic             rsp_valid,
    input  logic             rsp_fault,
    output logic             load,
    output logic [CNT_W-1:0] n_cfg,
    output logic [CNT_W-1:0] n_active,
    output logic [CNT_W-1:0] lane,
    output logic             req_valid,
    output logic             rsp_ready,
    output logic             wr_en,
    output logic             clr_mask,
    output logic             done,
    output logic             fault,
    output logic [CNT_W-1:0] fault_lane
);
    import gather_pkg::*;

    gstate_t state;

    // Element count implied by the configuration at start.
    always_comb begin
        if (cfg_idx64) n_cfg = cfg_wide ? CNT_W'(LANES / 2) : CNT_W'(LANES / 4);
        else           n_cfg = cfg_wide ? CNT_W'(LANES)     : CNT_W'(LANES / 2);
    end

    // Handshake and update strobes decoded from the state.
    always_comb begin
        load      = start && (state == ST_IDLE);
        req_valid = (state == ST_REQ);
        rsp_ready = (state == ST_WAIT);
        wr_en     = (state == ST_WAIT) && rsp_valid && !rsp_fault;
        clr_mask  = (state == ST_SCAN) && (lane == n_active);
    end

    // State, lane cursor, element count and the result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            lane       <= '0;
            n_active   <= '0;
            done       <= 1'b0;
            fault      <= 1'b0;
            fault_lane <= '0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    n_active <= n_cfg;
                    lane     <= '0;
                    state    <= ST_SCAN;
                end
                ST_SCAN: begin
                    if (lane == n_active) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else if (cur_en) begin
                        state <= ST_REQ;
                    end else begin
                        lane <= lane + 1'b1;
                    end
                end
                ST_REQ: if (req_ready) state <= ST_WAIT;
                ST_WAIT: if (rsp_valid) begin
                    if (rsp_fault) begin
                        fault      <= 1'b1;
                        fault_lane <= lane;
                        state      <= ST_IDLE;
                    end else begin
                        lane  <= lane + 1'b1;
                        state <= ST_SCAN;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/gather_seq.sv
// Top of the masked gather sequencer. It ties the address generator, the
// lane register file and the sequencer together. The read port allows one
// outstanding request; the caller must not pulse start to abandon a run.
module gather_seq #(
    parameter int LANES = 8,
    localparam int EW    = gather_pkg::ELEM_W,
    localparam int AW    = gather_pkg::ADDR_W,
    localparam int VW    = LANES * EW,
    localparam int CNT_W = $clog2(LANES + 1),
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cfg_wide,
    input  logic             cfg_idx64,
    input  logic [1:0]       cfg_scale,
    input  logic [AW-1:0]    base_addr,
    input  logic [VW-1:0]    index_vec,
    input  logic [VW-1:0]    dst_in,
    input  logic [VW-1:0]    mask_in,
    output logic [VW-1:0]    dst_out,
    output logic [VW-1:0]    mask_out,
    output logic             rd_req_valid,
    input  logic             rd_req_ready,
    output logic [AW-1:0]    rd_req_addr,
    input  logic             rd_rsp_valid,
    output logic             rd_rsp_ready,
    input  logic [EW-1:0]    rd_rsp_data,
    input  logic             rd_rsp_fault,
    output logic             done,
    output logic             fault,
    output logic [SEL_W-1:0] fault_lane
);
    logic             load_w, cur_en_w, wr_en_w, clr_w;
    logic [CNT_W-1:0] n_cfg_w, n_active_w, lane_w, fault_lane_w;

    gather_fsm #(.LANES(LANES), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_wide(cfg_wide), .cfg_idx64(cfg_idx64), .cur_en(cur_en_w),
        .req_ready(rd_req_ready), .rsp_valid(rd_rsp_valid), .rsp_fault(rd_rsp_fault),
        .load(load_w), .n_cfg(n_cfg_w), .n_active(n_active_w), .lane(lane_w),
        .req_valid(rd_req_valid), .rsp_ready(rd_rsp_ready), .wr_en(wr_en_w),
        .clr_mask(clr_w), .done(done), .fault(fault), .fault_lane(fault_lane_w)
    );

    gather_addr_gen #(.LANES(LANES), .CNT_W(CNT_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(load_w), .base_in(base_addr),
        .idx_in(index_vec), .idx64_in(cfg_idx64), .scale_in(cfg_scale),
        .lane(lane_w), .addr(rd_req_addr)
    );

    gather_lane_file #(.LANES(LANES), .CNT_W(CNT_W)) u_lanes (
        .clk(clk), .rst_n(rst_n), .load(load_w), .n_lanes(n_cfg_w),
        .dst_in(dst_in), .mask_in(mask_in), .wr_en(wr_en_w), .cur_lane(lane_w),
        .wr_data(rd_rsp_data), .clr_mask(clr_w), .dst_q(dst_out),
        .mask_q(mask_out), .cur_en(cur_en_w)
    );

    assign fault_lane = fault_lane_w[SEL_W-1:0];
endmodule

// File: rtl/gather_seq_chk.sv
// Protocol and result checks for gather_seq, attached with bind.
// Looks at the top's ports plus the sequencer's lane cursor and element count.
module gather_seq_chk #(
    parameter int LANES = 8,
    localparam int VW    = LANES * 32,
    localparam int CNT_W = $clog2(LANES + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req_valid,
    input logic             rd_req_ready,
    input logic [63:0]      rd_req_addr,
    input logic             rd_rsp_valid,
    input logic             rd_rsp_ready,
    input logic             rd_rsp_fault,
    input logic             done,
    input logic             fault,
    input logic [VW-1:0]    dst_out,
    input logic [VW-1:0]    mask_out,
    input logic [CNT_W-1:0] cur_lane,
    input logic [CNT_W-1:0] n_active
);
    logic [VW-1:0] hi_lanes;
    logic          cur_msb;

    // Lanes past the element count, and the enable bit under the cursor.
    always_comb begin
        cur_msb = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            hi_lanes[32*i +: 32] = (CNT_W'(i) >= n_active) ? '1 : '0;
            if (cur_lane == CNT_W'(i)) cur_msb = mask_out[32*i + 31];
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr)); // R5
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rsp_ready |-> !rd_req_valid); // R5
    AST_REQ_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> cur_msb); // R2
    AST_MASK_CLEARED_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rsp_valid && rd_rsp_ready && !rd_rsp_fault |=> mask_out[32*$past(cur_lane) + 31] == 1'b0); // R6
    AST_DONE_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> mask_out == '0); // R7
    AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault)); // R8
    AST_UNUSED_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |-> ((mask_out & hi_lanes) == '0) && ((dst_out & hi_lanes) == '0)); // R4
endmodule

bind gather_seq gather_seq_chk #(.LANES(LANES)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_fault(rd_rsp_fault), .done(done), .fault(fault), .dst_out(dst_out),
    .mask_out(mask_out), .cur_lane(lane_w), .n_active(n_active_w)
);

// File: tb/gather_seq_test.sv
module gather_seq_test;
    localparam int LANES = 8;
    localparam int VW    = LANES * 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           start = 1'b0, cfg_wide = 1'b0, cfg_idx64 = 1'b0;
    logic [1:0]     cfg_scale = '0;
    logic [63:0]    base_addr = '0;
    logic [VW-1:0]  index_vec = '0, dst_in = '0, mask_in = '0;
    logic [VW-1:0]  dst_out, mask_out;
    logic           rd_req_valid, rd_req_ready = 1'b0;
    logic [63:0]    rd_req_addr;
    logic           rd_rsp_valid = 1'b0, rd_rsp_ready;
    logic [31:0]    rd_rsp_data = '0;
    logic           rd_rsp_fault = 1'b0;
    logic           done, fault;
    logic [2:0]     fault_lane;

    gather_seq #(.LANES(LANES)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_wide(cfg_wide),
        .cfg_idx64(cfg_idx64), .cfg_scale(cfg_scale), .base_addr(base_addr),
        .index_vec(index_vec), .dst_in(dst_in), .mask_in(mask_in),
        .dst_out(dst_out), .mask_out(mask_out), .rd_req_valid(rd_req_valid),
        .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
        .rd_rsp_data(rd_rsp_data), .rd_rsp_fault(rd_rsp_fault),
        .done(done), .fault(fault), .fault_lane(fault_lane)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [31:0] rng = 32'h1357_9BDF;

    task automatic step_rng();
        rng = {rng[30:0], rng[31] ^ rng[21] ^ rng[1] ^ rng[0]};
    endtask

    function automatic logic [31:0] mem_word(input logic [63:0] a);
        return a[31:0] ^ a[63:32] ^ 32'h5A5A_0F0F;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Watchdog: an expired run is a failed check and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // One gather run against a behavioural model; fault_at is the ordinal of
    // the read that faults (-1: none). poke drives a stray start mid-run (R10).
    task automatic run_op(input bit wide, input bit idx64, input logic [1:0] sc,
                          input logic [63:0] base, input logic [VW-1:0] idx,
                          input logic [VW-1:0] d, input logic [VW-1:0] m,
                          input int fault_at, input bit poke, input string tag,
                          output logic [VW-1:0] got_dst, output logic [VW-1:0] got_msk);
        int n;
        logic [63:0] addrs[$];
        int lanes_q[$];
        logic [VW-1:0] exp_dst, exp_msk, hi;
        logic [63:0] ix;
        bit exp_fault, seen, pend, finished;
        int nreads, stop, rd, cur, dly, t;
        n = idx64 ? (wide ? 4 : 2) : (wide ? 8 : 4);
        exp_dst = '0; exp_msk = '0; hi = '0;
        for (int e = 0; e < LANES; e++) begin
            if (e < n) begin
                exp_dst[32*e +: 32] = d[32*e +: 32];
                exp_msk[32*e +: 32] = m[32*e +: 32];
            end else begin
                hi[32*e +: 32] = '1;
            end
        end
        for (int e = 0; e < n; e++) begin
            if (m[32*e + 31]) begin
                ix = idx64 ? idx[64*e +: 64] : {{32{idx[32*e + 31]}}, idx[32*e +: 32]};
                addrs.push_back(base + (ix << sc));
                lanes_q.push_back(e);
            end
        end
        nreads = addrs.size();
        exp_fault = (fault_at >= 0) && (fault_at < nreads);
        stop = exp_fault ? fault_at : nreads;
        for (int k = 0; k < stop; k++) begin
            exp_dst[32*lanes_q[k] +: 32] = mem_word(addrs[k]);
            exp_msk[32*lanes_q[k] +: 32] = '0;
        end
        if (!exp_fault) exp_msk = '0;

        @(negedge clk);
        cfg_wide = wide; cfg_idx64 = idx64; cfg_scale = sc; base_addr = base;
        index_vec = idx; dst_in = d; mask_in = m; start = 1'b1;
        rd = 0; cur = 0; dly = 0; seen = 0; pend = 0; finished = 0; t = 0;
        while (!finished && t < 3000) begin
            @(negedge clk);
            t++;
            start = 1'b0;
            if (poke && t == 3) begin
                start = 1'b1; cfg_wide = ~wide; cfg_idx64 = ~idx64;
                base_addr = ~base; index_vec = ~idx; dst_in = ~d; mask_in = '1;
            end
            if (t == 1)
                check(((dst_out & hi) == '0) && ((mask_out & hi) == '0),
                      {"R4/R3 unused lanes zeroed at start ", tag}, mask_out & hi, '0);
            rd_rsp_valid = 1'b0;
            if (done || fault) begin
                finished = 1;
            end else begin
                if (rd_req_valid) begin
                    if (!seen) begin
                        check(rd < nreads && rd_req_addr == addrs[rd],
                              {"R1/R5 read address in order ", tag}, VW'(rd_req_addr),
                              rd < nreads ? VW'(addrs[rd]) : '1);
                        seen = 1;
                    end
                    step_rng();
                    rd_req_ready = rng[0] | rng[1];
                    if (rd_req_ready) begin
                        pend = 1; dly = int'(rng[3:2]); seen = 0; cur = rd; rd++;
                    end
                end else begin
                    rd_req_ready = 1'b0;
                end
                if (pend && rd_rsp_ready) begin
                    if (dly == 0) begin
                        rd_rsp_valid = 1'b1;
                        rd_rsp_data  = (cur < nreads) ? mem_word(addrs[cur]) : 32'hDEAD_BEEF;
                        rd_rsp_fault = (cur == fault_at);
                        pend = 0;
                    end else begin
                        dly--;
                    end
                end
            end
        end
        rd_req_ready = 1'b0;
        rd_rsp_fault = 1'b0;
        check(finished, {"R7/R8 run ended ", tag}, VW'(t), VW'(3000));
        check(done == !exp_fault && fault == exp_fault,
              {exp_fault ? "R8 fault pulse " : "R7 done pulse ", tag},
              VW'({done, fault}), VW'({!exp_fault, exp_fault}));
        check(rd == (exp_fault ? fault_at + 1 : nreads),
              {"R2/R3 read count ", tag}, VW'(rd), VW'(exp_fault ? fault_at + 1 : nreads));
        check(dst_out == exp_dst, {"R6 destination ", tag}, dst_out, exp_dst);
        check(mask_out == exp_msk, {exp_fault ? "R8 mask " : "R7 mask ", tag}, mask_out, exp_msk);
        if (exp_fault)
            check(int'(fault_lane) == lanes_q[fault_at], {"R8 fault lane ", tag},
                  VW'(fault_lane), VW'(lanes_q[fault_at]));
        got_dst = dst_out;
        got_msk = mask_out;
        @(negedge clk);
        check(!done && !fault, {"R7 one-cycle pulse ", tag}, VW'({done, fault}), '0);
    endtask

    initial begin
        logic [VW-1:0] dq, mq, idx, d, m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rd_req_valid && !done && !fault && dst_out == '0 && mask_out == '0,
              "R5 reset state idle", VW'({rd_req_valid, done, fault}), '0);

        for (int e = 0; e < 8; e++) begin
            idx[32*e +: 32] = (e % 2 == 1) ? -32'(e * 3) : 32'(e * 100);
            d[32*e +: 32]   = 32'hD000_0000 + 32'(e);
        end
        m = {32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h8000_0001,
             32'h0000_0000, 32'h8000_0000, 32'h7000_0000, 32'h8123_4567};
        // Wide, 32-bit indices, scale 4, mixed mask including MSB-clear lanes (R2, R3).
        run_op(1, 0, 2'd2, 64'h0000_1000_0000_0000, idx, d, m, -1, 0, "wide32", dq, mq);
        // Narrow, 32-bit indices, scale 1 (R3, R4).
        run_op(0, 0, 2'd0, 64'h0000_0000_0040_0000, idx, d, '1, -1, 0, "narrow32", dq, mq);
        // Wide, 64-bit indices, scale 8, wrap near the top of the address space (R1).
        for (int e = 0; e < 4; e++)
            idx[64*e +: 64] = (e == 2) ? 64'h0000_0000_0000_0010 : -64'(e * 7 + 1);
        run_op(1, 1, 2'd3, 64'hFFFF_FFFF_FFFF_FFF0, idx, d, '1, -1, 0, "wide64", dq, mq);
        // Narrow, 64-bit indices, scale 2 (R3, R4).
        run_op(0, 1, 2'd1, 64'h1234_5678_0000_0000, idx, d, m, -1, 0, "narrow64", dq, mq);
        // No enabled lane: completes without reads (R9).
        run_op(1, 0, 2'd1, 64'h100, idx, d, {8{32'h7FFF_FFFF}}, -1, 0, "R9 empty mask", dq, mq);
        // Stray start mid-run has no effect (R10).
        run_op(1, 0, 2'd2, 64'h2000, idx, d, '1, -1, 1, "R10 ignored start", dq, mq);
        // Fault on the third read, then restart from the outputs (R8).
        run_op(1, 0, 2'd0, 64'h8000, idx, d, '1, 2, 0, "R8 fault mid", dq, mq);
        run_op(1, 0, 2'd0, 64'h8000, idx, dq, mq, -1, 0, "R8 restart", dq, mq);
        // Fault on the very first read, 64-bit narrow: unused lanes still zero (R4).
        run_op(0, 1, 2'd0, 64'h40, idx, d, '1, 0, 0, "R4 first-read fault", dq, mq);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule